// File: doc/BRIEF.md
# Dual-Channel Converter Serial Register Interface

This block is the digital front end of a two-channel 16-bit digital-to-analog converter. A host shifts 24-bit frames into it over a three-wire serial link: an active-low frame select, a serial clock and a data line. The serial lines are oversampled in the system clock domain, and data is taken on each falling edge of the serial clock. When a full frame has arrived, its command, channel address and data fields are decoded.

Each channel is double-buffered. A frame can load a channel's input register, move the input register into the DAC register, or do both at once. A hardware load input also moves the input registers into the DAC registers. It works in one of two ways: a low pulse on its own, or held low during a write so that the write reaches the DAC register at the end of the frame. A hardware clear forces both DAC registers to the reset code. A power-down command sets a 2-bit output-load mode for each channel. The reset code is zero scale or midscale, chosen by a parameter.

Top module: `dualdac_serial_front`

## Requirements
- R1: A frame is 24 bits, most significant bit first. A bit is taken on each serial-clock falling edge while `sync_n` is low. The frame is decoded on the 24th such edge. Later edges are ignored until `sync_n` goes high, which restarts the bit count.
- R2: If `sync_n` rises before 24 bits have arrived, the partial frame is dropped and no register changes.
- R3: Frame fields are: bits 23:22 ignored, bits 21:19 command, bits 18:16 address, bits 15:0 data. Command 000 loads the input register of the addressed channels. If `ldac_n` is high, the DAC register is left alone.
- R4: Command 001 copies the input register into the DAC register of the addressed channels. Command 011 loads both the input register and the DAC register with the data.
- R5: Address 000 selects channel A, 001 selects channel B and 111 selects both. Any other address, and the commands 010, 101, 110 and 111, change nothing.
- R6: Synchronous update: if `ldac_n` is low when a command-000 frame completes, the addressed DAC registers also take the data.
- R7: Asynchronous update: a falling edge on `ldac_n` copies both input registers into both DAC registers.
- R8: While `clr_n` is low, both DAC registers are forced to the reset code from the next clock edge on. The input registers are kept.
- R9: After reset, the input and DAC registers hold the reset code and both power-down modes are 00. The reset code is 0x0000 when `MIDSCALE_RESET`=0 and 0x8000 when it is 1.
- R10: Command 100 sets the power-down mode from data bits 5:4 (00 normal, 01 1 k to ground, 10 100 k to ground, 11 three-state). The mode goes to channel A when data bit 0 is set and to channel B when data bit 1 is set. The address field is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst_n | input | 1 | Active-low power-on reset |
| sclk | input | 1 | Serial clock; data taken on its falling edge |
| sync_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data, most significant bit first |
| ldac_n | input | 1 | Active-low load strobe for the DAC registers |
| clr_n | input | 1 | Active-low clear of both DAC registers |
| dac_a | output | 16 | Channel A DAC register |
| dac_b | output | 16 | Channel B DAC register |
| pd_a | output | 2 | Channel A power-down mode |
| pd_b | output | 2 | Channel B power-down mode |

## Verification
The bench sends a frame cut short at 12 bits and then a valid frame. A design that kept the partial bits would corrupt a register or misalign the next frame. It sends a frame followed by extra clock edges. A design that kept shifting would decode the wrong bits. It uses reserved addresses and unused commands, which a loose decoder would act on. It also checks that a write made with the load strobe held low updates the DAC register, while a plain write does not. Finally it clears, then updates from the input registers, which exposes a clear that wipes the input registers as well.

// File: rtl/dualdac_serial_front.sv
module dualdac_serial_front #(
  parameter int DW             = 16,
  parameter int FRAME_BITS     = 24,
  parameter bit MIDSCALE_RESET = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          sync_n,
  input  logic          din,
  input  logic          ldac_n,
  input  logic          clr_n,
  output logic [DW-1:0] dac_a,
  output logic [DW-1:0] dac_b,
  output logic [1:0]    pd_a,
  output logic [1:0]    pd_b
);
  localparam int NCH = 2;
  localparam int CW  = $clog2(FRAME_BITS + 1);
  localparam logic [DW-1:0] RST_CODE = MIDSCALE_RESET ? {1'b1, {(DW-1){1'b0}}} : '0;
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME_BITS);

  logic                  sclk_q, ldac_q;
  logic [CW-1:0]         cnt;
  logic [FRAME_BITS-1:0] sr;
  logic [DW-1:0]         inp [NCH];
  logic [DW-1:0]         dac [NCH];
  logic [1:0]            pd  [NCH];

  wire sclk_fall = sclk_q & ~sclk;
  wire shift_en  = sclk_fall & ~sync_n & (cnt != FULL);
  wire done      = shift_en & (cnt == LAST);
  wire ldac_fall = ldac_q & ~ldac_n;

  wire [FRAME_BITS-1:0] sr_nxt = {sr[FRAME_BITS-2:0], din};
  wire [2:0]    cmd  = sr_nxt[DW+5:DW+3];
  wire [2:0]    addr = sr_nxt[DW+2:DW];
  wire [DW-1:0] data = sr_nxt[DW-1:0];

  wire [NCH-1:0] sel = {addr == 3'd1 || addr == 3'd7, addr == 3'd0 || addr == 3'd7};

  wire wr_in  = done & (cmd == 3'b000 || cmd == 3'b011);
  wire wr_dac = done & (cmd == 3'b011 || (cmd == 3'b000 && !ldac_n));
  wire upd    = done & (cmd == 3'b001);
  wire pd_wr  = done & (cmd == 3'b100);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ldac_q <= 1'b1;
      cnt    <= '0;
      sr     <= '0;
    end else begin
      sclk_q <= sclk;
      ldac_q <= ldac_n;
      if (sync_n)        cnt <= '0;
      else if (shift_en) cnt <= cnt + 1'b1;
      if (shift_en) sr <= sr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        inp[i] <= RST_CODE;
        dac[i] <= RST_CODE;
        pd[i]  <= 2'b00;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_in && sel[i]) inp[i] <= data;
        if (!clr_n)                dac[i] <= RST_CODE;
        else if (wr_dac && sel[i]) dac[i] <= data;
        else if (upd && sel[i])    dac[i] <= inp[i];
        else if (ldac_fall)        dac[i] <= inp[i];
        if (pd_wr && data[i]) pd[i] <= data[5:4];
      end
    end
  end

  assign dac_a = dac[0];
  assign dac_b = dac[1];
  assign pd_a  = pd[0];
  assign pd_b  = pd[1];

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL);
  // R1
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n) sync_n |=> cnt == '0);
  // R8
  clear_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (dac_a == RST_CODE && dac_b == RST_CODE));
  // R7
  async_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_fall && clr_n && !done) |=> (dac_a == $past(inp[0]) && dac_b == $past(inp[1])));
  // R2
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !ldac_fall && clr_n) |=> ($stable(dac_a) && $stable(dac_b)));
  // R10
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(pd_a) && $stable(pd_b)));
endmodule

// File: tb/dualdac_serial_front_tb.sv
module dualdac_serial_front_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, sync_n = 1'b1, din = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
  logic [15:0] dac_a, dac_b, dac_a2, dac_b2;
  logic [1:0]  pd_a, pd_b, pd_a2, pd_b2;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  dualdac_serial_front dut_i (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n),
    .din(din), .ldac_n(ldac_n), .clr_n(clr_n), .dac_a(dac_a), .dac_b(dac_b),
    .pd_a(pd_a), .pd_b(pd_b));

  dualdac_serial_front #(.MIDSCALE_RESET(1'b1)) mid_i (.clk(clk), .rst_n(rst_n),
    .sclk(sclk), .sync_n(sync_n), .din(din), .ldac_n(ldac_n), .clr_n(clr_n),
    .dac_a(dac_a2), .dac_b(dac_b2), .pd_a(pd_a2), .pd_b(pd_b2));

  // {frame, ldac held low, expected A, expected B, expected {pd_b,pd_a}}
  localparam int NV = 10;
  localparam logic [60:0] VEC [NV] = '{
    {24'h001234, 1'b0, 16'h0000, 16'h0000, 4'h0},  // R3 input only
    {24'h080000, 1'b0, 16'h1234, 16'h0000, 4'h0},  // R4 update A
    {24'h19ABCD, 1'b0, 16'h1234, 16'hABCD, 4'h0},  // R4 write+update B
    {24'h075555, 1'b1, 16'h5555, 16'h5555, 4'h0},  // R6 sync, both
    {24'h1AFFFF, 1'b0, 16'h5555, 16'h5555, 4'h0},  // R5 bad address
    {24'h200031, 1'b0, 16'h5555, 16'h5555, 4'h3},  // R10 A three-state
    {24'h200012, 1'b0, 16'h5555, 16'h5555, 4'h7},  // R10 B 1k
    {24'h0100FF, 1'b0, 16'h5555, 16'h5555, 4'h7},  // R3 input B only
    {24'h170000, 1'b0, 16'h5555, 16'h5555, 4'h7},  // R5 unused command
    {24'h1F8001, 1'b0, 16'h8001, 16'h8001, 4'h7}   // R4 write+update both
  };

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] f, input int nbits, input int extra);
    sync_n = 1'b0;
    wait_clk(2);
    for (int i = 0; i < nbits + extra; i++) begin
      sclk = 1'b1;
      din  = (i < 24) ? f[23-i] : 1'b1;
      wait_clk(2);
      sclk = 1'b0;
      wait_clk(2);
    end
    sclk = 1'b1;
    wait_clk(2);
    sync_n = 1'b1;
    wait_clk(3);
  endtask

  initial begin
    wait_clk(3);
    check("R9 reset dac", {dac_a, dac_b}, 32'h0);
    check("R9 reset pd", {28'h0, pd_b, pd_a}, 32'h0);
    check("R9 midscale reset", {dac_a2, dac_b2}, 32'h80008000);
    rst_n = 1'b1;
    wait_clk(3);

    for (int v = 0; v < NV; v++) begin
      ldac_n = ~VEC[v][36];
      wait_clk(2);
      send(VEC[v][60:37], 24, 0);
      ldac_n = 1'b1;
      wait_clk(3);
      check($sformatf("R1 vector %0d dac", v), {dac_a, dac_b}, VEC[v][35:4]);
      check($sformatf("R10 vector %0d pd", v), {28'h0, VEC[v][3:0]}, {28'h0, pd_b, pd_a});
    end

    send(24'h001111, 24, 0);
    check("R3 no update without load", {dac_a, dac_b}, 32'h80018001);
    ldac_n = 1'b0; wait_clk(3); ldac_n = 1'b1; wait_clk(3);
    check("R7 async load", {dac_a, dac_b}, 32'h11118001);

    send(24'h1F0000, 12, 0);
    check("R2 partial frame dropped", {dac_a, dac_b}, 32'h11118001);
    send(24'h182222, 24, 0);
    check("R2 frame after partial", {dac_a, dac_b}, 32'h22228001);

    send(24'h193333, 24, 4);
    check("R1 extra edges ignored", {dac_a, dac_b}, 32'h22223333);

    clr_n = 1'b0; wait_clk(2);
    check("R8 clear zero", {dac_a, dac_b}, 32'h0);
    check("R8 clear midscale", {dac_a2, dac_b2}, 32'h80008000);
    clr_n = 1'b1; wait_clk(2);
    send(24'h0F0000, 24, 0);
    check("R8 input kept over clear", {dac_a, dac_b}, 32'h22223333);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule